// File: doc/BRIEF.md
# Infrared Mark/Space Interval Timer

This block measures the pulse train coming out of a demodulating infrared receiver. The receiver output idles high and pulls low while a carrier burst is present, so a low pin means "mark" and a high pin means "space". The block synchronises the pin, finds its edges and, for every interval that ends, emits a one-cycle record holding the interval's meaning (mark or space) and its length in ticks. A prescaler divides the system clock into ticks (64 clocks per tick by default, one microsecond at 64 MHz).

A single free-running tick counter is cleared only when the pin rises (end of a mark, start of a space). A falling pin therefore reports the space length as the counter value itself, and that value is kept. The next rising pin reports the mark length as the counter minus the kept value. A programmable limit raises a one-cycle timeout when the counter equals it while the pin idles high, which lets software close a frame once the line has gone quiet. The timeout is suppressed while a mark is in progress.

Top module: `ir_pulse_timer`

## Requirements
- R1: The pin passes through a SYNC_LEN-flop synchroniser. A high-to-low pin change produces a record with `rec_level` = 0 (space ended). A low-to-high change produces one with `rec_level` = 1 (mark ended). Each record is a single-cycle `rec_valid` pulse.
- R2: The tick counter is cleared on every rising edge and only then. A space record carries the counter value at the falling edge, which is the number of ticks since the last rising edge. That value is stored as the falling capture.
- R3: A mark record carries the counter value at the rising edge minus the stored falling capture.
- R4: The counter advances by one every PRESCALE clock cycles. A rising edge also restarts the prescaler.
- R5: The counter counts from 0 up to WRAP_AT and then returns to 0.
- R6: `timeout_pulse` is a single-cycle pulse raised when the counter equals `timeout_limit` while the synchronised pin is high. It fires at most once until the next edge.
- R7: No timeout is raised while the synchronised pin is low, even when the counter passes the limit.
- R8: Any edge rearms the timeout, so each idle period may raise one.
- R9: When an edge is detected in the same cycle that the counter equals the limit, the edge's record is produced and no timeout is raised.
- R10: While `enable` is low, no records or timeouts are produced and the counter, prescaler and falling capture are held at zero. After re-enabling, the first mark record counts from the enable.
- R11: After reset, `rec_valid`, `rec_level`, `rec_duration` and `timeout_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Capture and timeout active when high |
| ir_in | input | 1 | Receiver output, low = mark |
| timeout_limit | input | CNT_W | Tick count at which an idle line times out |
| rec_valid | output | 1 | One-cycle strobe for a finished interval |
| rec_level | output | 1 | 1 = mark ended, 0 = space ended |
| rec_duration | output | CNT_W | Interval length in ticks |
| timeout_pulse | output | 1 | One-cycle idle-line timeout |

## Verification
Two functions can fall in the same cycle: the counter equals the timeout limit in exactly the cycle where a rising edge is detected. The bench provokes this by timing a space of 3 ticks and a mark of 5 ticks with the limit set to 8. The rising edge then lands on the match with the pin newly high. It judges the result by requiring a mark record of 5 and no timeout in that cycle or the next few. It then requires exactly one timeout once the restarted counter reaches 8 again.

// File: rtl/ir_pulse_timer.sv
module ir_pulse_timer #(
  parameter int unsigned PRESCALE = 64,
  parameter int unsigned CNT_W    = 32,
  parameter logic [CNT_W-1:0] WRAP_AT = CNT_W'(32'h7FFFFFFE),
  parameter int unsigned SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             ir_in,
  input  logic [CNT_W-1:0] timeout_limit,
  output logic             rec_valid,
  output logic             rec_level,
  output logic [CNT_W-1:0] rec_duration,
  output logic             timeout_pulse
);

  localparam int unsigned PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [SYNC_LEN-1:0] sync_q;
  logic                line_d;
  logic [PRE_W-1:0]    pre;
  logic [CNT_W-1:0]    cnt;
  logic [CNT_W-1:0]    fall_cap;
  logic                armed;

  wire line     = sync_q[SYNC_LEN-1];
  wire rise     = enable & line & ~line_d;
  wire fall     = enable & ~line & line_d;
  wire tick     = (pre == PRE_LAST);
  wire [CNT_W-1:0] cnt_next = (cnt == WRAP_AT) ? '0 : cnt + 1'b1;
  wire idle_hit = armed & line & (cnt == timeout_limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q        <= '1;
      line_d        <= 1'b1;
      pre           <= '0;
      cnt           <= '0;
      fall_cap      <= '0;
      armed         <= 1'b1;
      rec_valid     <= 1'b0;
      rec_level     <= 1'b0;
      rec_duration  <= '0;
      timeout_pulse <= 1'b0;
    end else begin
      sync_q        <= {sync_q[SYNC_LEN-2:0], ir_in};
      line_d        <= line;
      rec_valid     <= 1'b0;
      timeout_pulse <= 1'b0;
      if (!enable) begin
        pre      <= '0;
        cnt      <= '0;
        fall_cap <= '0;
        armed    <= 1'b1;
      end else if (rise) begin
        rec_valid    <= 1'b1;
        rec_level    <= 1'b1;
        rec_duration <= cnt - fall_cap;
        pre          <= '0;
        cnt          <= '0;
        armed        <= 1'b1;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) cnt <= cnt_next;
        if (fall) begin
          rec_valid    <= 1'b1;
          rec_level    <= 1'b0;
          rec_duration <= cnt;
          fall_cap     <= cnt;
          armed        <= 1'b1;
        end else if (idle_hit) begin
          timeout_pulse <= 1'b1;
          armed         <= 1'b0;
        end
      end
    end
  end

  // R1
  level_matches_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_level == line_d));

  // R5
  count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= WRAP_AT);

  // R6
  timeout_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |=> !timeout_pulse);

  // R7
  timeout_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> line_d);

  // R9
  edge_beats_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rec_valid && timeout_pulse));

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!rec_valid && !timeout_pulse && cnt == '0 && fall_cap == '0));

endmodule

// File: tb/ir_pulse_timer_test.sv
module ir_pulse_timer_test;
  localparam int P = 4;
  localparam int W = 32;
  localparam int NV = 6;
  localparam int SP_T [NV] = '{2, 1, 5, 3, 4, 7};
  localparam int MK_T [NV] = '{3, 1, 2, 7, 4, 1};
  localparam int EXP_SP [NV] = '{2, 1, 5, 3, 4, 7};
  localparam int EXP_MK [NV] = '{3, 1, 2, 7, 4, 1};

  logic clk = 0, rst_n = 0, enable = 0, ir_in = 1;
  logic [W-1:0] timeout_limit = 30;
  logic rec_valid, rec_level, timeout_pulse;
  logic [W-1:0] rec_duration;

  int checks = 0, errors = 0;
  int rec_n = 0, to_n = 0;
  logic rec_lvl_a [64];
  int   rec_dur_a [64];
  bit   done = 0;

  always #10 clk = ~clk;

  ir_pulse_timer #(.PRESCALE(P), .CNT_W(W), .WRAP_AT(32'd20), .SYNC_LEN(2)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ir_in(ir_in),
    .timeout_limit(timeout_limit), .rec_valid(rec_valid), .rec_level(rec_level),
    .rec_duration(rec_duration), .timeout_pulse(timeout_pulse));

  always @(negedge clk) if (rst_n) begin
    if (rec_valid && rec_n < 64) begin
      rec_lvl_a[rec_n] = rec_level;
      rec_dur_a[rec_n] = int'(rec_duration);
    end
    if (rec_valid) rec_n++;
    if (timeout_pulse) to_n++;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  int base, snap_r, snap_t;

  initial begin
    cyc(3);
    chk("R11 rec_valid", int'(rec_valid), 0);
    chk("R11 timeout_pulse", int'(timeout_pulse), 0);
    chk("R11 rec_duration", int'(rec_duration), 0);
    rst_n = 1;
    cyc(2);
    chk("R11 after release", int'(rec_valid | timeout_pulse | rec_level), 0);
    enable = 1;
    cyc(4);

    base = rec_n;
    ir_in = 0; cyc(8);
    ir_in = 1;
    for (int i = 0; i < NV; i++) begin
      cyc(SP_T[i] * P + P / 2);
      ir_in = 0;
      cyc(MK_T[i] * P);
      ir_in = 1;
    end
    cyc(5);
    chk("R1 record count", rec_n - base, 2 + 2 * NV);
    for (int i = 0; i < NV; i++) begin
      chk("R1 space level", int'(rec_lvl_a[base + 2 + 2 * i]), 0);
      chk("R2 R4 space ticks", rec_dur_a[base + 2 + 2 * i], EXP_SP[i]);
      chk("R1 mark level", int'(rec_lvl_a[base + 3 + 2 * i]), 1);
      chk("R3 R4 mark ticks", rec_dur_a[base + 3 + 2 * i], EXP_MK[i]);
    end

    timeout_limit = 5;
    snap_t = to_n;
    cyc(10 * P);
    chk("R6 one timeout per idle", to_n - snap_t, 1);
    snap_t = to_n;
    cyc(6 * P);
    chk("R6 no repeat", to_n - snap_t, 0);

    ir_in = 0; cyc(2 * P);
    ir_in = 1; cyc(2 * P);
    snap_t = to_n;
    ir_in = 0; cyc(10 * P);
    chk("R7 no timeout while low", to_n - snap_t, 0);
    ir_in = 1; cyc(10 * P);
    chk("R8 rearmed by edge", to_n - snap_t, 1);

    timeout_limit = 8;
    ir_in = 0; cyc(2 * P);
    ir_in = 1;
    cyc(3 * P + P / 2);
    ir_in = 0;
    cyc(5 * P);
    snap_t = to_n; snap_r = rec_n;
    ir_in = 1;
    cyc(2 * P);
    chk("R9 mark recorded", rec_n - snap_r, 1);
    if (rec_n - snap_r == 1) chk("R9 mark ticks", rec_dur_a[snap_r], 5);
    chk("R9 no timeout on edge", to_n - snap_t, 0);
    cyc(10 * P);
    chk("R9 timeout after restart", to_n - snap_t, 1);

    timeout_limit = 30;
    ir_in = 0; cyc(2 * P);
    ir_in = 1;
    cyc(25 * P + P / 2);
    snap_r = rec_n;
    ir_in = 0;
    cyc(5);
    chk("R5 wrap record", rec_n - snap_r, 1);
    if (rec_n - snap_r == 1) chk("R5 wrapped space", rec_dur_a[snap_r], 4);

    enable = 0;
    timeout_limit = 0;
    cyc(3);
    snap_r = rec_n; snap_t = to_n;
    ir_in = 1; cyc(8);
    ir_in = 0; cyc(8);
    ir_in = 1; cyc(8);
    ir_in = 0; cyc(8);
    chk("R10 no records disabled", rec_n - snap_r, 0);
    chk("R10 no timeouts disabled", to_n - snap_t, 0);
    timeout_limit = 30;
    enable = 1;
    cyc(12);
    ir_in = 1;
    cyc(5);
    chk("R10 record after enable", rec_n - snap_r, 1);
    if (rec_n - snap_r == 1) chk("R10 cleared capture", rec_dur_a[snap_r], 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule